// File: doc/BRIEF.md
# GPIO Controller Register Bank

This block is the register file of a general-purpose pin bank with 95 pins by default. It sits on a simple 32-bit read/write bus. Through that bus the host stores the per-pin controls that drive the pads: output level, drive direction, function select and weak pull. It also reads back each pin's sampled input level. A set of shared bitmap registers holds, for every pin, its ownership flag, its interrupt redirection flag, its latched interrupt status and its interrupt enable. A single global register picks the interrupt routing.

There are two kinds of register. Bitmap registers pack 32 pins per word. The word offset is the group base plus (pin / 32) * 4, and the bit within the word is pin % 32. Configuration registers come as a pair of words per pin, starting at 0x100 and spaced 8 bytes apart. Pad inputs pass through a two-flop synchronizer. Each pin can turn its input sensing off, and a disabled pin reads its input level as 0. Edge and level detection live outside the block. The detector pulses `irq_set` and the block keeps the sticky status, which is cleared by writing 1. A read returns its data on `rdata` one clock after the request, and `rdata` holds that value until the next read.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every pin's config word 1 reads 0x00000004 (direction input, function native, output low, edge trigger, no invert) and config word 2 reads 0x00000004 (sensing off, no pull). All bitmaps, `irq_route`, `pad_oe` and `pad_out` are 0.
- R2: The ownership, redirection and enable bitmaps sit at 0x00, 0x10 and 0x90, and status sits at 0x80. Pin p uses word base+(p/32)*4, bit p%32. Ownership, redirection and enable are read/write and drive `host_own`, `redir_en` and the interrupt gating. Bits for pins at or above NUM_PINS read 0.
- R3: Pin p's config word 1 is at 0x100+8p and word 2 is at 0x104+8p. A write to one pin's words leaves every other pin unchanged.
- R4: Config word 1 has these fields. Bit 31 is the output level and drives `pad_out`. Bit 4 is the level/edge trigger select and drives `trig_level`. Bit 3 is the polarity invert and drives `trig_inv`. Bit 2 is the direction (1 input). Bits 1:0 are the function select and drive `pin_func[2p+1:2p]`. Bit 30 is read-only, and all other bits read 0.
- R5: `pad_oe[p]` is 1 exactly when pin p has direction 0 and function select 1. Otherwise it is 0.
- R6: Config word 2 bits 1:0 select the pull: 1 asserts `pull_dn`, 2 asserts `pull_up`, and 0 or 3 asserts neither. Bit 2 is the sensing disable. The written value reads back.
- R7: With sensing enabled, config word 1 bit 30 shows `pad_in[p]` after a two-flop synchronizer. A change is not visible to a read latched at the first rising edge after it, and it is visible to a read latched at the third. With sensing disabled, bit 30 reads 0.
- R8: A status bit is set by `irq_set[p]`. Writing 1 to a status bit clears it, and writing 0 leaves it alone. A set in the same cycle as a clear wins.
- R9: `irq_out` is high whenever any pin has both its status bit and its enable bit set.
- R10: Bit 0 of the word at 0x7C is read/write and drives `irq_route`. Its other bits read 0.
- R11: Reads of unmapped offsets return 0. This includes 0x0C and 0x40, and per-pin words at 0x100+8*NUM_PINS and above. Writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Bus access strobe |
| we | input | 1 | 1 write, 0 read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Output level per pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| pull_up | output | NUM_PINS | Weak pull-up enable |
| pull_dn | output | NUM_PINS | Weak pull-down enable |
| pin_func | output | 2*NUM_PINS | Function select per pin |
| trig_level | output | NUM_PINS | Trigger type to detector (1 level) |
| trig_inv | output | NUM_PINS | Trigger polarity invert to detector |
| host_own | output | NUM_PINS | Ownership bitmap (1 host) |
| redir_en | output | NUM_PINS | Redirection bitmap |
| irq_set | input | NUM_PINS | Detected-event pulses |
| irq_out | output | 1 | Combined enabled interrupt |
| irq_route | output | 1 | Global interrupt route select |

## Verification
The embedded assertions watch pin 0 on every cycle. They check the output-enable rule after each configuration write, that a disabled input reads 0 in bit 30, that status set and write-one-clear take effect on the next edge, and that reads past the last pin return zero. Only the bench scenarios cover the rest. These are the bitmap word and bit arithmetic across all three words, isolation between neighbouring pins, and the exact synchronizer latency. They also cover set-over-clear priority, pull decoding for every code, and writes to unmapped offsets leaving real registers untouched.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int NUM_PINS = 95,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pull_up,
  output logic [NUM_PINS-1:0]   pull_dn,
  output logic [2*NUM_PINS-1:0] pin_func,
  output logic [NUM_PINS-1:0]   trig_level,
  output logic [NUM_PINS-1:0]   trig_inv,
  output logic [NUM_PINS-1:0]   host_own,
  output logic [NUM_PINS-1:0]   redir_en,
  input  logic [NUM_PINS-1:0]   irq_set,
  output logic                  irq_out,
  output logic                  irq_route
);

  // Bitmap words are selected by addr[3:2], so at most 128 pins fit.
  localparam int PW = $clog2(NUM_PINS);
  localparam int XW = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] PIN_END = ADDR_W'(256 + NUM_PINS * 8);

  logic              low_page, pin_hit, wr;
  logic [3:0]        grp;
  logic [1:0]        bw;
  logic [XW-1:0]     pidx;
  logic [PW-1:0]     pn;
  logic              wr_own, wr_red, wr_sts, wr_ena;

  assign low_page = (addr[ADDR_W-1:8] == '0);
  assign grp      = addr[7:4];
  assign bw       = addr[3:2];
  assign pidx     = addr[ADDR_W-1:3] - XW'(32);
  assign pin_hit  = !low_page && (pidx < XW'(NUM_PINS));
  assign pn       = pidx[PW-1:0];
  assign wr       = req & we;
  assign wr_own   = wr & low_page & (grp == 4'h0);
  assign wr_red   = wr & low_page & (grp == 4'h1);
  assign wr_sts   = wr & low_page & (grp == 4'h8);
  assign wr_ena   = wr & low_page & (grp == 4'h9);

  logic [NUM_PINS-1:0]   out_v, dir_v, trl_v, inv_v, dis_v, own_v, red_v, sts_v, ena_v;
  logic [2*NUM_PINS-1:0] use_v, pull_v;
  logic [NUM_PINS-1:0]   sync1, sync2, sense;
  logic                  route_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int W = i / 32;
    localparam int B = i % 32;
    logic       wsel, c1, c2;
    logic       out_r, dir_r, trl_r, inv_r, dis_r, own_r, red_r, sts_r, ena_r;
    logic [1:0] use_r, pull_r;

    assign wsel = (bw == 2'(W));
    assign c1   = wr & pin_hit & (pn == PW'(i)) & ~addr[2];
    assign c2   = wr & pin_hit & (pn == PW'(i)) &  addr[2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_r  <= 1'b0;
        dir_r  <= 1'b1;
        trl_r  <= 1'b0;
        inv_r  <= 1'b0;
        use_r  <= 2'd0;
        dis_r  <= 1'b1;
        pull_r <= 2'd0;
        own_r  <= 1'b0;
        red_r  <= 1'b0;
        ena_r  <= 1'b0;
        sts_r  <= 1'b0;
      end else begin
        if (c1) begin
          out_r <= wdata[31];
          trl_r <= wdata[4];
          inv_r <= wdata[3];
          dir_r <= wdata[2];
          use_r <= wdata[1:0];
        end
        if (c2) begin
          dis_r  <= wdata[2];
          pull_r <= wdata[1:0];
        end
        if (wr_own && wsel) own_r <= wdata[B];
        if (wr_red && wsel) red_r <= wdata[B];
        if (wr_ena && wsel) ena_r <= wdata[B];
        if (irq_set[i])                         sts_r <= 1'b1;
        else if (wr_sts && wsel && wdata[B])    sts_r <= 1'b0;
      end
    end

    assign out_v[i]        = out_r;
    assign dir_v[i]        = dir_r;
    assign trl_v[i]        = trl_r;
    assign inv_v[i]        = inv_r;
    assign dis_v[i]        = dis_r;
    assign own_v[i]        = own_r;
    assign red_v[i]        = red_r;
    assign sts_v[i]        = sts_r;
    assign ena_v[i]        = ena_r;
    assign use_v[2*i +: 2] = use_r;
    assign pull_v[2*i +: 2] = pull_r;

    assign pad_oe[i]  = ~dir_r & (use_r == 2'd1);
    assign pull_up[i] = (pull_r == 2'd2);
    assign pull_dn[i] = (pull_r == 2'd1);
  end

  assign pad_out    = out_v;
  assign pin_func   = use_v;
  assign trig_level = trl_v;
  assign trig_inv   = inv_v;
  assign host_own   = own_v;
  assign redir_en   = red_v;
  assign irq_out    = |(sts_v & ena_v);
  assign irq_route  = route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
    end
  end
  assign sense = sync2 & ~dis_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                              route_q <= 1'b0;
    else if (wr && low_page && grp == 4'h7 && bw == 2'd3)    route_q <= wdata[0];
  end

  logic [127:0] own_w, red_w, sts_w, ena_w;
  always_comb begin
    own_w = '0; red_w = '0; sts_w = '0; ena_w = '0;
    own_w[NUM_PINS-1:0] = own_v;
    red_w[NUM_PINS-1:0] = red_v;
    sts_w[NUM_PINS-1:0] = sts_v;
    ena_w[NUM_PINS-1:0] = ena_v;
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (low_page) begin
      case (grp)
        4'h0: rd_mux = own_w[{bw, 5'b0} +: 32];
        4'h1: rd_mux = red_w[{bw, 5'b0} +: 32];
        4'h7: if (bw == 2'd3) rd_mux = {31'b0, route_q};
        4'h8: rd_mux = sts_w[{bw, 5'b0} +: 32];
        4'h9: rd_mux = ena_w[{bw, 5'b0} +: 32];
        default: rd_mux = '0;
      endcase
    end else if (pin_hit) begin
      if (addr[2])
        rd_mux = {29'b0, dis_v[pn], pull_v[{pn, 1'b0} +: 2]};
      else
        rd_mux = {out_v[pn], sense[pn], 25'b0, trl_v[pn], inv_v[pn],
                  dir_v[pn], use_v[{pn, 1'b0} +: 2]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (req && !we) rdata <= rd_mux;
  end

  a_r5_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == ADDR_W'(256) && wdata[2:0] == 3'b001) |=> pad_oe[0]);

  a_r5_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == ADDR_W'(256) && wdata[2]) |=> !pad_oe[0]);

  a_r7_sense_off: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && addr == ADDR_W'(256) && dis_v[0]) |=> !rdata[30]);

  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set[0] |=> sts_v[0]);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr == ADDR_W'(128) && wdata[0] && !irq_set[0]) |=> !sts_v[0]);

  a_r11_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && addr >= PIN_END) |=> (rdata == 32'd0));

endmodule

// File: tb/gpio_bank_regs_tb.sv
module gpio_bank_regs_tb;
  localparam int N = 95;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] pad_in = '0, irq_set = '0;
  logic [N-1:0] pad_out, pad_oe, pull_up, pull_dn, trig_level, trig_inv, host_own, redir_en;
  logic [2*N-1:0] pin_func;
  logic irq_out, irq_route;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_bank_regs #(.NUM_PINS(N), .ADDR_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_up(pull_up), .pull_dn(pull_dn), .pin_func(pin_func),
    .trig_level(trig_level), .trig_inv(trig_inv), .host_own(host_own),
    .redir_en(redir_en), .irq_set(irq_set), .irq_out(irq_out), .irq_route(irq_route));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rdchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_reset;
    rdchk("R1 cfg1 pin0", 12'h100, 32'h4);
    rdchk("R1 cfg2 pin0", 12'h104, 32'h4);
    rdchk("R1 cfg1 pin94", 12'h3F0, 32'h4);
    rdchk("R1 own word0", 12'h000, 32'h0);
    rdchk("R1 route", 12'h07C, 32'h0);
    chk("R1 pad_oe", {31'b0, |pad_oe}, 32'h0);
    chk("R1 pad_out", {31'b0, |pad_out}, 32'h0);
  endtask

  task automatic t_bitmaps;
    wr(12'h004, 32'hA5A5_0001);
    rdchk("R2 own word1", 12'h004, 32'hA5A5_0001);
    chk("R2 host_own pin32", {31'b0, host_own[32]}, 32'h1);
    chk("R2 host_own pin34", {31'b0, host_own[34]}, 32'h0);
    wr(12'h018, 32'hFFFF_FFFF);
    rdchk("R2 redir word2 top bit absent", 12'h018, 32'h7FFF_FFFF);
    chk("R2 redir pin94", {31'b0, redir_en[94]}, 32'h1);
    chk("R2 redir pin63", {31'b0, redir_en[63]}, 32'h0);
    wr(12'h090, 32'h3);
    rdchk("R2 enable word0", 12'h090, 32'h3);
  endtask

  task automatic t_cfg1;
    wr(12'h228, 32'hC000_001D);
    rdchk("R4 cfg1 pin37 bit30 read-only", 12'h228, 32'h8000_001D);
    chk("R4 pad_out37", {31'b0, pad_out[37]}, 32'h1);
    chk("R4 trig_level37", {31'b0, trig_level[37]}, 32'h1);
    chk("R4 trig_inv37", {31'b0, trig_inv[37]}, 32'h1);
    chk("R4 pin_func37", {30'b0, pin_func[75:74]}, 32'h1);
    chk("R5 pad_oe37 input", {31'b0, pad_oe[37]}, 32'h0);
    rdchk("R3 neighbour pin36", 12'h220, 32'h4);
    rdchk("R3 neighbour pin38", 12'h230, 32'h4);
    rdchk("R3 cfg2 pin37", 12'h22C, 32'h4);
  endtask

  task automatic t_oe;
    wr(12'h128, 32'h1);
    chk("R5 oe dir0 gpio", {31'b0, pad_oe[5]}, 32'h1);
    wr(12'h128, 32'h2);
    chk("R5 oe func2", {31'b0, pad_oe[5]}, 32'h0);
    wr(12'h128, 32'h5);
    chk("R5 oe dir input", {31'b0, pad_oe[5]}, 32'h0);
    wr(12'h128, 32'h0);
    chk("R5 oe native", {31'b0, pad_oe[5]}, 32'h0);
  endtask

  task automatic t_pull;
    wr(12'h154, 32'h1);
    chk("R6 pull code1", {30'b0, pull_up[10], pull_dn[10]}, 32'h1);
    wr(12'h154, 32'h2);
    chk("R6 pull code2", {30'b0, pull_up[10], pull_dn[10]}, 32'h2);
    wr(12'h154, 32'h3);
    chk("R6 pull code3", {30'b0, pull_up[10], pull_dn[10]}, 32'h0);
    rdchk("R6 cfg2 readback", 12'h154, 32'h3);
    wr(12'h154, 32'h0);
    chk("R6 pull code0", {30'b0, pull_up[10], pull_dn[10]}, 32'h0);
  endtask

  task automatic t_sense;
    pad_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    rdchk("R7 sensing off reads 0", 12'h100, 32'h4);
    wr(12'h104, 32'h0);
    rdchk("R7 sensing on high", 12'h100, 32'h4000_0004);
    pad_in[0] = 1'b0;
    rdchk("R7 sync first edge old", 12'h100, 32'h4000_0004);
    @(negedge clk);
    rdchk("R7 sync third edge new", 12'h100, 32'h4);
    pad_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    wr(12'h104, 32'h4);
    rdchk("R7 disabled again", 12'h100, 32'h4);
  endtask

  task automatic t_irq;
    wr(12'h090, 32'h8);
    irq_set[3] = 1'b1;
    @(negedge clk);
    irq_set[3] = 1'b0;
    chk("R9 irq_out after set", {31'b0, irq_out}, 32'h1);
    rdchk("R8 status set", 12'h080, 32'h8);
    wr(12'h080, 32'h0);
    rdchk("R8 write 0 keeps", 12'h080, 32'h8);
    wr(12'h080, 32'h8);
    rdchk("R8 write 1 clears", 12'h080, 32'h0);
    chk("R9 irq_out cleared", {31'b0, irq_out}, 32'h0);
    irq_set[4] = 1'b1;
    @(negedge clk);
    chk("R9 not enabled", {31'b0, irq_out}, 32'h0);
    wr(12'h080, 32'h10);
    irq_set[4] = 1'b0;
    rdchk("R8 set wins", 12'h080, 32'h10);
    wr(12'h080, 32'h10);
    rdchk("R8 cleared after", 12'h080, 32'h0);
    irq_set[70] = 1'b1;
    @(negedge clk);
    irq_set[70] = 1'b0;
    rdchk("R2 status word2 bit6", 12'h088, 32'h40);
  endtask

  task automatic t_route;
    wr(12'h07C, 32'hFFFF_FFFF);
    chk("R10 route set", {31'b0, irq_route}, 32'h1);
    rdchk("R10 route read", 12'h07C, 32'h1);
    wr(12'h07C, 32'hFFFF_FFFE);
    chk("R10 route clear", {31'b0, irq_route}, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(12'h00C, 32'hFFFF_FFFF);
    rdchk("R11 read 0x0C", 12'h00C, 32'h0);
    rdchk("R11 own word0 intact", 12'h000, 32'h0);
    rdchk("R11 own word1 intact", 12'h004, 32'hA5A5_0001);
    rdchk("R11 own word2 intact", 12'h008, 32'h0);
    wr(12'h040, 32'hFFFF_FFFF);
    rdchk("R11 read 0x40", 12'h040, 32'h0);
    wr(12'h3F8, 32'hFFFF_FFFF);
    rdchk("R11 past last pin", 12'h3F8, 32'h0);
    rdchk("R11 pin94 intact", 12'h3F0, 32'h4);
    rdchk("R11 pin94 cfg2 intact", 12'h3F4, 32'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bitmaps();
    t_cfg1();
    t_oe();
    t_pull();
    t_sense();
    t_irq();
    t_route();
    t_unmapped();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule